// File: doc/BRIEF.md
# PLL Self-Calibration Sequencer

This block is the control sequencer that decides when a clock-multiplier PLL runs its internal self-calibration, and what the outputs do around it. A calibration can be requested in two ways: software sets a one-shot calibrate bit, or the oscillator reports that its internal setting has left its usable range. The request waits until the selected input clock is valid and the reference clock is present. Only then does the block hand a start pulse to the calibration engine. That engine is an abstract collaborator: it answers with a done pulse, and in the bench a small model plays its part.

While calibration runs, loss-of-lock stays high. The output clock is either left running, with a wandering frequency, or squelched, depending on a squelch bit that clears itself after a success. After a first success, losing the input drops the block into digital hold, and the input's return relocks it with no new calibration. A new calibration is started automatically when the input frequency count drifts away from the count captured at the last success by about 500 ppm or more. A soft-reset strobe returns everything to the power-up state.

Top module: `pllcal_seq`

## Requirements
- R1: A pulse on `calBitSet`, or `dcoOutOfRange` high, makes `calPending` read 1 after the next clock edge.
- R2: `engStart` is a single-cycle pulse. It is issued only when a request is pending, `inAlarm` is 0, `inSelected` is 1 and `refPresent` is 1. Otherwise the request stays pending. `calPending` reads 0 in the cycle in which `engStart` is high.
- R3: With `sqBit` at 0, `outClkEn` is 1 for the whole calibration, starting in the cycle `engStart` is high.
- R4: With `sqBit` at 1, `outClkEn` is 0 for the whole calibration and becomes 1 once the calibration completes.
- R5: `sqBit` reads 0 after a calibration completes successfully.
- R6: `lossOfLock` is 1 out of reset and during calibration. It reads 0 in the cycle after `engDone` is seen during calibration.
- R7: After a successful calibration, `inAlarm` high or `inSelected` low moves the block to hold. In hold, `holdMode` is 1, `lossOfLock` is 1 and `outClkEn` stays 1.
- R8: Leaving hold when the input becomes valid again relocks the block directly: `lossOfLock` goes to 0 and no `engStart` pulse is issued.
- R9: While locked, a new calibration starts when |`freqCount` − latched count| is nonzero and at least (latched count >> 11). The latched count is captured at the end of each successful calibration. With a latched count of 40000 the threshold is 19: a drift of 18 starts nothing, and a drift of 19 starts a calibration.
- R10: An `inAlarm` during a calibration started from the never-calibrated state aborts it. The block returns to idle with `lossOfLock` 1, `outClkEn` 0 and `holdMode` 0, and `sqBit` keeps its value.
- R11: A `softRst` pulse returns the block to its reset state after the next clock edge: `lossOfLock` 1, `outClkEn` 0, `holdMode` 0, `calPending` 0, `sqBit` 0, and the block treats itself as never calibrated.
- R12: After `rstN` is released: `engStart` 0, `outClkEn` 0, `lossOfLock` 1, `holdMode` 0, `calPending` 0, `sqBit` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| calBitSet | input | 1 | Software write of 1 to the calibrate bit (one-cycle pulse) |
| sqBitWrite | input | 1 | Software write strobe for the squelch bit |
| sqBitVal | input | 1 | Value written to the squelch bit |
| softRst | input | 1 | Soft-reset strobe |
| dcoOutOfRange | input | 1 | Oscillator setting out of range |
| inAlarm | input | 1 | Alarm on the selected input clock |
| inSelected | input | 1 | Input clock is selected as active |
| refPresent | input | 1 | Reference clock present |
| freqCount | input | CNT_W | Frequency measurement count of the selected input |
| engDone | input | 1 | Calibration engine completion pulse |
| engStart | output | 1 | Calibration engine start pulse |
| outClkEn | output | 1 | Output clock enable |
| lossOfLock | output | 1 | Loss-of-lock flag |
| holdMode | output | 1 | Digital hold indication |
| calPending | output | 1 | Calibrate request pending |
| sqBit | output | 1 | Current squelch bit |

## Verification
The hardest situation to reach is a calibration that an alarm aborts before the block has ever completed one. The same alarm after a success must lead to hold instead. The stimulus first soft-resets the block to clear its calibrated history and sets the squelch bit. It then stalls the engine model so that it never answers, issues a request, and raises the alarm while calibration is still running. The drift boundary is reached by holding the input count steady during a calibration so that a known value is latched, then stepping the count to one below and exactly at the threshold.

// File: rtl/pllcal_pkg.sv
package pllcal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CAL    = 2'd1,
    ST_LOCKED = 2'd2,
    ST_HOLD   = 2'd3
  } calState_t;

  // strobes from the control FSM into the datapath
  typedef struct packed {
    logic latchCnt;  // capture frequency count at successful end
    logic clrSq;     // self-clear the squelch bit
    logic clrPend;   // request accepted
    logic clrAll;    // soft reset
  } dpStrobe_t;

endpackage

// File: rtl/pllcal_dp.sv
module pllcal_dp
  import pllcal_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int DRIFT_SHIFT = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             calBitSet,
  input  logic             dcoOutOfRange,
  input  logic             sqBitWrite,
  input  logic             sqBitVal,
  input  logic [CNT_W-1:0] freqCount,
  output logic             pending,
  output logic             sqBit,
  output logic             drift
);

  logic [CNT_W-1:0] latchedCnt;
  logic [CNT_W-1:0] cntDiff;
  logic [CNT_W-1:0] driftThr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (strobe.clrAll) begin
      pending <= 1'b0;
    end else if (calBitSet || dcoOutOfRange) begin
      pending <= 1'b1;
    end else if (strobe.clrPend) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqBit <= 1'b0;
    end else if (strobe.clrAll) begin
      sqBit <= 1'b0;
    end else if (sqBitWrite) begin
      sqBit <= sqBitVal;
    end else if (strobe.clrSq) begin
      sqBit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchedCnt <= '0;
    end else if (strobe.clrAll) begin
      latchedCnt <= '0;
    end else if (strobe.latchCnt) begin
      latchedCnt <= freqCount;
    end
  end

  always_comb begin
    cntDiff  = (freqCount >= latchedCnt) ? (freqCount - latchedCnt)
                                         : (latchedCnt - freqCount);
    driftThr = latchedCnt >> DRIFT_SHIFT;
    drift    = (cntDiff != '0) && (cntDiff >= driftThr);
  end

endmodule

// File: rtl/pllcal_ctrl.sv
module pllcal_ctrl
  import pllcal_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      softRst,
  input  logic      pending,
  input  logic      drift,
  input  logic      sqBit,
  input  logic      inAlarm,
  input  logic      inSelected,
  input  logic      refPresent,
  input  logic      engDone,
  output dpStrobe_t strobe,
  output logic      engStart,
  output logic      outClkEn,
  output logic      lossOfLock,
  output logic      holdMode,
  output logic      calActive
);

  calState_t state, stateNext;
  logic everCal, everCalNext;
  logic startNext;
  logic inputOk;

  assign inputOk = !inAlarm && inSelected && refPresent;

  always_comb begin
    stateNext   = state;
    everCalNext = everCal;
    startNext   = 1'b0;
    strobe      = '0;
    unique case (state)
      ST_IDLE: begin
        if (pending && inputOk) begin
          stateNext      = ST_CAL;
          startNext      = 1'b1;
          strobe.clrPend = 1'b1;
        end
      end
      ST_CAL: begin
        if (engDone) begin
          stateNext       = ST_LOCKED;
          everCalNext     = 1'b1;
          strobe.latchCnt = 1'b1;
          strobe.clrSq    = 1'b1;
        end else if (inAlarm) begin
          stateNext = everCal ? ST_HOLD : ST_IDLE;
        end
      end
      ST_LOCKED: begin
        if (inAlarm || !inSelected) begin
          stateNext = ST_HOLD;
        end else if ((pending || drift) && refPresent) begin
          stateNext      = ST_CAL;
          startNext      = 1'b1;
          strobe.clrPend = 1'b1;
        end
      end
      ST_HOLD: begin
        if (inputOk) begin
          stateNext = ST_LOCKED;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (softRst) begin
      stateNext     = ST_IDLE;
      everCalNext   = 1'b0;
      startNext     = 1'b0;
      strobe        = '0;
      strobe.clrAll = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      everCal  <= 1'b0;
      engStart <= 1'b0;
    end else begin
      state    <= stateNext;
      everCal  <= everCalNext;
      engStart <= startNext;
    end
  end

  always_comb begin
    calActive  = (state == ST_CAL);
    holdMode   = (state == ST_HOLD);
    lossOfLock = (state != ST_LOCKED);
    unique case (state)
      ST_IDLE: outClkEn = 1'b0;
      ST_CAL:  outClkEn = !sqBit;
      default: outClkEn = 1'b1;
    endcase
  end

endmodule

// File: rtl/pllcal_seq.sv
module pllcal_seq
  import pllcal_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int DRIFT_SHIFT = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             calBitSet,
  input  logic             sqBitWrite,
  input  logic             sqBitVal,
  input  logic             softRst,
  input  logic             dcoOutOfRange,
  input  logic             inAlarm,
  input  logic             inSelected,
  input  logic             refPresent,
  input  logic [CNT_W-1:0] freqCount,
  input  logic             engDone,
  output logic             engStart,
  output logic             outClkEn,
  output logic             lossOfLock,
  output logic             holdMode,
  output logic             calPending,
  output logic             sqBit
);

  dpStrobe_t strobe;
  logic      drift;
  logic      calActive;

  pllcal_dp #(
    .CNT_W      (CNT_W),
    .DRIFT_SHIFT(DRIFT_SHIFT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .calBitSet    (calBitSet),
    .dcoOutOfRange(dcoOutOfRange),
    .sqBitWrite   (sqBitWrite),
    .sqBitVal     (sqBitVal),
    .freqCount    (freqCount),
    .pending      (calPending),
    .sqBit        (sqBit),
    .drift        (drift)
  );

  pllcal_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .softRst   (softRst),
    .pending   (calPending),
    .drift     (drift),
    .sqBit     (sqBit),
    .inAlarm   (inAlarm),
    .inSelected(inSelected),
    .refPresent(refPresent),
    .engDone   (engDone),
    .strobe    (strobe),
    .engStart  (engStart),
    .outClkEn  (outClkEn),
    .lossOfLock(lossOfLock),
    .holdMode  (holdMode),
    .calActive (calActive)
  );

endmodule

// File: rtl/pllcal_seq_chk.sv
module pllcal_seq_chk (
  input logic clk,
  input logic rstN,
  input logic calBitSet,
  input logic sqBitWrite,
  input logic softRst,
  input logic inAlarm,
  input logic inSelected,
  input logic refPresent,
  input logic engDone,
  input logic engStart,
  input logic outClkEn,
  input logic lossOfLock,
  input logic holdMode,
  input logic calPending,
  input logic sqBit,
  input logic calActive
);

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> $past(!inAlarm && inSelected && refPresent && !softRst));

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  assert_start_clears_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && !$past(calBitSet)) |-> !calPending);

  assert_run_clock_R3: assert property (@(posedge clk) disable iff (!rstN)
    (calActive && !sqBit) |-> outClkEn);

  assert_squelch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (calActive && sqBit) |-> !outClkEn);

  assert_sq_selfclear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (calActive && engDone && !sqBitWrite && !softRst) |=> !sqBit);

  assert_lock_after_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (calActive && engDone && !softRst) |=> !lossOfLock);

  assert_lol_in_cal_R6: assert property (@(posedge clk) disable iff (!rstN)
    calActive |-> lossOfLock);

  assert_hold_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdMode) |-> $past(inAlarm || !inSelected));

  assert_hold_outputs_R7: assert property (@(posedge clk) disable iff (!rstN)
    holdMode |-> (outClkEn && lossOfLock));

  assert_relock_no_cal_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdMode) |-> !engStart);

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (lossOfLock && !outClkEn && !holdMode && !calPending && !sqBit));

endmodule

bind pllcal_seq pllcal_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .calBitSet (calBitSet),
  .sqBitWrite(sqBitWrite),
  .softRst   (softRst),
  .inAlarm   (inAlarm),
  .inSelected(inSelected),
  .refPresent(refPresent),
  .engDone   (engDone),
  .engStart  (engStart),
  .outClkEn  (outClkEn),
  .lossOfLock(lossOfLock),
  .holdMode  (holdMode),
  .calPending(calPending),
  .sqBit     (sqBit),
  .calActive (calActive)
);

// File: tb/pllcal_seq_tb.sv
`timescale 1ns/1ps
module pllcal_seq_tb;

  localparam int CNT_W   = 20;
  localparam int ENG_LEN = 5;
  localparam logic [CNT_W-1:0] BASE_CNT = 20'd40000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic calBitSet = 1'b0, sqBitWrite = 1'b0, sqBitVal = 1'b0, softRst = 1'b0;
  logic dcoOutOfRange = 1'b0, inAlarm = 1'b0, inSelected = 1'b1, refPresent = 1'b1;
  logic [CNT_W-1:0] freqCount = BASE_CNT;
  logic engDone;
  logic engStart, outClkEn, lossOfLock, holdMode, calPending, sqBit;

  int checks = 0;
  int errors = 0;
  int startCount = 0;
  int engCnt = 0;
  logic engHang = 1'b0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  pllcal_seq #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .calBitSet(calBitSet), .sqBitWrite(sqBitWrite),
    .sqBitVal(sqBitVal), .softRst(softRst), .dcoOutOfRange(dcoOutOfRange),
    .inAlarm(inAlarm), .inSelected(inSelected), .refPresent(refPresent),
    .freqCount(freqCount), .engDone(engDone), .engStart(engStart),
    .outClkEn(outClkEn), .lossOfLock(lossOfLock), .holdMode(holdMode),
    .calPending(calPending), .sqBit(sqBit)
  );

  // calibration engine model: answers ENG_LEN cycles after a start
  always @(posedge clk) begin
    if (engStart) startCount <= startCount + 1;
    if (engStart && !engHang) engCnt <= ENG_LEN;
    else if (engCnt > 0) engCnt <= engCnt - 1;
  end
  assign engDone = (engCnt == 1);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulseCal();
    calBitSet = 1'b1; tick(1); calBitSet = 1'b0;
  endtask

  task automatic doSoftRst();
    softRst = 1'b1; tick(1); softRst = 1'b0;
  endtask

  task automatic waitLock(input string req);
    int n = 0;
    while (lossOfLock && n < 60) begin tick(1); n++; end
    chk(req, "lossOfLock after calibration", int'(lossOfLock), 0);
  endtask

  task automatic testReset();
    chk("R12", "engStart", int'(engStart), 0);
    chk("R12", "outClkEn", int'(outClkEn), 0);
    chk("R12", "lossOfLock", int'(lossOfLock), 1);
    chk("R12", "holdMode", int'(holdMode), 0);
    chk("R12", "calPending", int'(calPending), 0);
    chk("R12", "sqBit", int'(sqBit), 0);
  endtask

  // gated request, then free-running clock during calibration
  task automatic testGatedRequest();
    int s0;
    refPresent = 1'b0;
    s0 = startCount;
    pulseCal();
    chk("R1", "calPending after write", int'(calPending), 1);
    tick(3);
    chk("R2", "no start while reference missing", startCount - s0, 0);
    chk("R2", "request still pending", int'(calPending), 1);
    refPresent = 1'b1;
    tick(1);
    chk("R2", "engStart when gate opens", int'(engStart), 1);
    chk("R2", "pending cleared on accept", int'(calPending), 0);
    chk("R3", "outClkEn during cal, no squelch", int'(outClkEn), 1);
    chk("R6", "lossOfLock during cal", int'(lossOfLock), 1);
    tick(1);
    chk("R2", "engStart single cycle", int'(engStart), 0);
    chk("R3", "outClkEn mid cal", int'(outClkEn), 1);
    waitLock("R6");
    chk("R6", "outClkEn when locked", int'(outClkEn), 1);
  endtask

  task automatic testHold();
    int s0;
    s0 = startCount;
    inAlarm = 1'b1;
    tick(1);
    chk("R7", "holdMode on alarm", int'(holdMode), 1);
    chk("R7", "lossOfLock in hold", int'(lossOfLock), 1);
    chk("R7", "outClkEn in hold", int'(outClkEn), 1);
    inAlarm = 1'b0;
    tick(1);
    chk("R8", "holdMode after input returns", int'(holdMode), 0);
    chk("R8", "lossOfLock after relock", int'(lossOfLock), 0);
    inSelected = 1'b0;
    tick(1);
    chk("R7", "holdMode on deselect", int'(holdMode), 1);
    inSelected = 1'b1;
    tick(3);
    chk("R8", "no calibration on relock", startCount - s0, 0);
    chk("R8", "locked after reselect", int'(lossOfLock), 0);
  endtask

  task automatic testDrift();
    int s0;
    s0 = startCount;
    freqCount = BASE_CNT + 20'd18;
    tick(4);
    chk("R9", "no cal at drift 18", startCount - s0, 0);
    chk("R9", "still locked at drift 18", int'(lossOfLock), 0);
    freqCount = BASE_CNT + 20'd19;
    tick(1);
    chk("R9", "engStart at drift 19", int'(engStart), 1);
    freqCount = BASE_CNT;
    waitLock("R9");
    tick(3);
    chk("R9", "single cal after drift", startCount - s0, 1);
  endtask

  task automatic testDco();
    int s0;
    s0 = startCount;
    dcoOutOfRange = 1'b1;
    tick(1);
    dcoOutOfRange = 1'b0;
    chk("R1", "calPending after out-of-range", int'(calPending), 1);
    tick(1);
    chk("R1", "engStart after out-of-range", int'(engStart), 1);
    waitLock("R1");
    chk("R1", "one calibration", startCount - s0, 1);
  endtask

  task automatic testSquelch();
    doSoftRst();
    sqBitWrite = 1'b1; sqBitVal = 1'b1; tick(1); sqBitWrite = 1'b0;
    chk("R4", "sqBit written", int'(sqBit), 1);
    pulseCal();
    tick(1);
    chk("R4", "engStart", int'(engStart), 1);
    chk("R4", "outClkEn off during cal", int'(outClkEn), 0);
    tick(2);
    chk("R4", "outClkEn still off", int'(outClkEn), 0);
    waitLock("R6");
    chk("R4", "outClkEn after cal", int'(outClkEn), 1);
    chk("R5", "sqBit self-cleared", int'(sqBit), 0);
  endtask

  task automatic testAbort();
    doSoftRst();
    sqBitWrite = 1'b1; sqBitVal = 1'b1; tick(1); sqBitWrite = 1'b0;
    engHang = 1'b1;
    pulseCal();
    tick(1);
    chk("R10", "engStart", int'(engStart), 1);
    tick(2);
    inAlarm = 1'b1;
    tick(1);
    chk("R10", "holdMode after abort", int'(holdMode), 0);
    chk("R10", "lossOfLock after abort", int'(lossOfLock), 1);
    chk("R10", "outClkEn after abort", int'(outClkEn), 0);
    chk("R10", "sqBit kept", int'(sqBit), 1);
    inAlarm = 1'b0;
    tick(3);
    chk("R10", "stays idle", int'(outClkEn), 0);
    engHang = 1'b0;
  endtask

  task automatic testSoftReset();
    pulseCal();
    tick(1);
    waitLock("R11");
    sqBitWrite = 1'b1; sqBitVal = 1'b1; tick(1); sqBitWrite = 1'b0;
    doSoftRst();
    chk("R11", "lossOfLock", int'(lossOfLock), 1);
    chk("R11", "outClkEn", int'(outClkEn), 0);
    chk("R11", "holdMode", int'(holdMode), 0);
    chk("R11", "sqBit", int'(sqBit), 0);
    chk("R11", "calPending", int'(calPending), 0);
    inAlarm = 1'b1;
    tick(2);
    chk("R11", "no hold after reset (never calibrated)", int'(holdMode), 0);
    inAlarm = 1'b0;
    tick(1);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    testReset();
    testGatedRequest();
    testHold();
    testDrift();
    testDco();
    testSquelch();
    testAbort();
    testSoftReset();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule